// File: doc/BRIEF.md
# DMA Channel Block and Repeat Sequencer

This block is the counting and address-stepping core of a single DMA channel. Software programs it through a byte-wide register port with a block length, a repeat budget, a 24-bit source address and a control byte. A trigger pulse starts one block. Every "beat done" strobe from the bus side then moves the source address one step and counts down the block. The block ends when the count is used up. The bus master, the destination path, arbitration and interrupt routing sit outside this block.

A programmed block length of zero means the longest possible block, 65535 beats. With repeat mode off, the channel switches itself off after one block. With repeat mode on, a nonzero repeat budget is counted down by one per block, and the channel switches off when the budget reaches zero. A budget of zero lets the channel repeat without limit.

The source address is loaded as a unit. The two lower bytes wait in a staging register, and the address changes only when the top byte is written. Each block runs from a working copy of the length, so the programmed length reads back unchanged.

Top module: `blkrep_seq`

## Requirements
- R1: After reset, the control byte (offset 0) reads 0x00, the repeat byte (offset 1) reads 0x00, each length byte (offsets 2 low, 3 high) reads 0x01, `src_addr` is 0, and `chan_en`, `blk_done` and `xact_done` are low.
- R2: A `trigger` that arrives while the channel is enabled and idle starts a block, and `beat_done` strobes count only while a block runs. The block ends on the strobe that uses up the programmed length. `blk_done` is high for exactly the one cycle after the clock edge that took that strobe.
- R3: A programmed length of 0 gives a block of 65535 beats.
- R4: After each accepted beat, the source address steps according to control bits [3:2]. The codes are 0 hold, 1 plus one, 2 minus one and 3 hold, and the address wraps modulo 2^24.
- R5: Bytes written to offsets 4 (low) and 5 (middle) go to a staging register and leave `src_addr` unchanged. A write to offset 6 (high) loads all three bytes into the address at once. Offsets 4 to 6 read back the live address.
- R6: With repeat mode off (control bit 1 = 0), the end of a block clears the enable. `xact_done` pulses in the same cycle as `blk_done`, and `chan_en` is low in that cycle.
- R7: With repeat mode on and a nonzero repeat count, each finished block lowers the count (read at offset 1) by one. The block that brings it to zero clears the enable and pulses `xact_done`.
- R8: With repeat mode on and a repeat count of 0, the channel stays enabled after every block, the count stays 0 and `xact_done` never pulses.
- R9: A `trigger` during a running block does not restart or lengthen it. `beat_done` while no block runs leaves the address unchanged. A `trigger` while the channel is disabled starts nothing.
- R10: The programmed length reads back unchanged after blocks have run.
- R11: Control bit 0 enables the channel, and offset 0 reads back the live enable in bit 0. Writing 0 to the enable bit stops a running block, and later beats have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write offset |
| reg_wdata | input | 8 | Register write data |
| reg_raddr | input | 4 | Register read offset |
| reg_rdata | output | 8 | Register read data (combinational) |
| trigger | input | 1 | Block start request |
| beat_done | input | 1 | One beat of the current block finished |
| src_addr | output | 24 | Current source address |
| chan_en | output | 1 | Channel enabled |
| blk_done | output | 1 | One-cycle pulse at the end of each block |
| xact_done | output | 1 | One-cycle pulse when the channel switches itself off |

## Verification
The checker watches several rules on every cycle:
- `xact_done` always comes with `blk_done` and a low enable.
- `blk_done` never lasts two cycles.
- A block can begin only after a trigger.
- Staged address writes never move the address.
- An upward step adds exactly one.
- The repeat count drops by exactly one per finished block.

Other behaviour is visible only from whole scenarios in the bench. This covers the exact block length for every programmed value, including the 65535-beat case. It also covers the point at which a limited repeat run stops, an unlimited run staying alive, and triggers being ignored during a block.

// File: rtl/blkrep_pkg.sv
package blkrep_pkg;

  typedef enum logic [1:0] {
    DIR_HOLD  = 2'd0,
    DIR_UP    = 2'd1,
    DIR_DOWN  = 2'd2,
    DIR_HOLD3 = 2'd3
  } dir_e;

  localparam int OFF_CTRL = 0;
  localparam int OFF_REP  = 1;
  localparam int OFF_LEN  = 2;
  localparam int OFF_ADR  = 4;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_RPT = 1;
  localparam int CTRL_DIR = 2;

endpackage

// File: rtl/blkrep_regs.sv
module blkrep_regs
  import blkrep_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 24,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [7:0]        reg_wdata,
  output logic [LEN_W-1:0]  prog_len,
  output logic              rpt_mode,
  output dir_e              dir,
  output logic              ctrl_wr,
  output logic              rep_wr,
  output logic              adr_commit,
  output logic [ADDR_W-1:0] adr_value
);

  localparam int LEN_BYTES = LEN_W / 8;
  localparam int ADR_BYTES = ADDR_W / 8;
  localparam int STG_W     = ADDR_W - 8;
  localparam int ADR_TOP   = OFF_ADR + ADR_BYTES - 1;

  logic [STG_W-1:0] stage;

  function automatic logic hit(input logic [REG_AW-1:0] a, input int off);
    return a == REG_AW'(off);
  endfunction

  assign ctrl_wr    = reg_we && hit(reg_waddr, OFF_CTRL);
  assign rep_wr     = reg_we && hit(reg_waddr, OFF_REP);
  assign adr_commit = reg_we && hit(reg_waddr, ADR_TOP);
  assign adr_value  = {reg_wdata, stage};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LEN_BYTES; i++) prog_len[i*8 +: 8] <= 8'h01;
    end else if (reg_we) begin
      for (int i = 0; i < LEN_BYTES; i++)
        if (hit(reg_waddr, OFF_LEN + i)) prog_len[i*8 +: 8] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
    end else if (reg_we) begin
      for (int i = 0; i < ADR_BYTES - 1; i++)
        if (hit(reg_waddr, OFF_ADR + i)) stage[i*8 +: 8] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_mode <= 1'b0;
      dir      <= DIR_HOLD;
    end else if (ctrl_wr) begin
      rpt_mode <= reg_wdata[CTRL_RPT];
      dir      <= dir_e'(reg_wdata[CTRL_DIR +: 2]);
    end
  end

endmodule

// File: rtl/blkrep_blkcnt.sv
module blkrep_blkcnt #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] prog_len,
  input  logic             dec,
  output logic [LEN_W-1:0] work,
  output logic             last
);

  // zero programmed means the longest block
  function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] p);
    return (p == '0) ? {LEN_W{1'b1}} : p;
  endfunction

  assign last = (work == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       work <= '0;
    else if (load)    work <= eff_len(prog_len);
    else if (dec)     work <= work - LEN_W'(1);
  end

endmodule

// File: rtl/blkrep_addr.sv
module blkrep_addr
  import blkrep_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [ADDR_W-1:0] commit_val,
  input  logic              step,
  input  dir_e              dir,
  output logic [ADDR_W-1:0] addr
);

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                  input dir_e d);
    case (d)
      DIR_UP:   return a + ADDR_W'(1);
      DIR_DOWN: return a - ADDR_W'(1);
      default:  return a;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (commit)  addr <= commit_val;
    else if (step)    addr <= next_addr(addr, dir);
  end

endmodule

// File: rtl/blkrep_seq.sv
module blkrep_seq
  import blkrep_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int REP_W  = 8,
  parameter int ADDR_W = 24,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [7:0]        reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [7:0]        reg_rdata,
  input  logic              trigger,
  input  logic              beat_done,
  output logic [ADDR_W-1:0] src_addr,
  output logic              chan_en,
  output logic              blk_done,
  output logic              xact_done
);

  localparam int LEN_BYTES = LEN_W / 8;
  localparam int ADR_BYTES = ADDR_W / 8;

  logic [LEN_W-1:0]  prog_len;
  logic [LEN_W-1:0]  work;
  logic              rpt_mode;
  dir_e              dir;
  logic              ctrl_wr, rep_wr, adr_commit;
  logic [ADDR_W-1:0] adr_value;
  logic              busy;
  logic [REP_W-1:0]  rep_cnt;
  logic              work_last;

  // named events
  logic start_evt, beat_acc, blk_last, fin_evt, stop_wr;

  blkrep_regs #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .prog_len(prog_len), .rpt_mode(rpt_mode),
    .dir(dir), .ctrl_wr(ctrl_wr), .rep_wr(rep_wr),
    .adr_commit(adr_commit), .adr_value(adr_value)
  );

  blkrep_blkcnt #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(start_evt), .prog_len(prog_len),
    .dec(beat_acc), .work(work), .last(work_last)
  );

  blkrep_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .commit(adr_commit), .commit_val(adr_value),
    .step(beat_acc), .dir(dir), .addr(src_addr)
  );

  assign stop_wr   = ctrl_wr && !reg_wdata[CTRL_EN];
  assign start_evt = trigger && chan_en && !busy && !ctrl_wr;
  assign beat_acc  = beat_done && busy && !stop_wr;
  assign blk_last  = beat_acc && work_last;
  assign fin_evt   = blk_last && (!rpt_mode || rep_cnt == REP_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en   <= 1'b0;
      busy      <= 1'b0;
      rep_cnt   <= '0;
      blk_done  <= 1'b0;
      xact_done <= 1'b0;
    end else begin
      if (ctrl_wr)      chan_en <= reg_wdata[CTRL_EN];
      else if (fin_evt) chan_en <= 1'b0;

      if (stop_wr)        busy <= 1'b0;
      else if (start_evt) busy <= 1'b1;
      else if (blk_last)  busy <= 1'b0;

      if (rep_wr)
        rep_cnt <= reg_wdata[REP_W-1:0];
      else if (blk_last && rpt_mode && rep_cnt != '0)
        rep_cnt <= rep_cnt - REP_W'(1);

      blk_done  <= blk_last;
      xact_done <= fin_evt;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_raddr == REG_AW'(OFF_CTRL))
      reg_rdata = {4'b0000, dir, rpt_mode, chan_en};
    if (reg_raddr == REG_AW'(OFF_REP))
      reg_rdata = 8'(rep_cnt);
    for (int i = 0; i < LEN_BYTES; i++)
      if (reg_raddr == REG_AW'(OFF_LEN + i)) reg_rdata = prog_len[i*8 +: 8];
    for (int i = 0; i < ADR_BYTES; i++)
      if (reg_raddr == REG_AW'(OFF_ADR + i)) reg_rdata = src_addr[i*8 +: 8];
  end

endmodule

// File: rtl/blkrep_seq_chk.sv
module blkrep_seq_chk
  import blkrep_pkg::*;
#(
  parameter int REP_W  = 8,
  parameter int ADDR_W = 24,
  parameter int REG_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_waddr,
  input logic              trigger,
  input logic              busy,
  input logic              beat_acc,
  input logic              blk_last,
  input logic              adr_commit,
  input logic              rpt_mode,
  input dir_e              dir,
  input logic [REP_W-1:0]  rep_cnt,
  input logic              rep_wr,
  input logic [ADDR_W-1:0] src_addr,
  input logic              chan_en,
  input logic              blk_done,
  input logic              xact_done
);

  logic stage_wr;
  assign stage_wr = reg_we && (reg_waddr == REG_AW'(OFF_ADR) ||
                               reg_waddr == REG_AW'(OFF_ADR + 1));

  a_r6_xact_with_blk: assert property (@(posedge clk) disable iff (!rst_n)
    xact_done |-> (blk_done && !chan_en));

  a_r2_blk_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);

  a_r9_start_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trigger));

  a_r5_stage_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_wr && !beat_acc) |=> $stable(src_addr));

  a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_acc && !adr_commit && dir == DIR_UP) |=>
      src_addr == ADDR_W'($past(src_addr) + ADDR_W'(1)));

  a_r7_rep_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_last && rpt_mode && rep_cnt != '0 && !rep_wr) |=>
      rep_cnt == REP_W'($past(rep_cnt) - REP_W'(1)));

  a_r11_busy_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> chan_en);

endmodule

bind blkrep_seq blkrep_seq_chk #(.REP_W(REP_W), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
  .trigger(trigger), .busy(busy), .beat_acc(beat_acc), .blk_last(blk_last),
  .adr_commit(adr_commit), .rpt_mode(rpt_mode), .dir(dir), .rep_cnt(rep_cnt),
  .rep_wr(rep_wr), .src_addr(src_addr), .chan_en(chan_en),
  .blk_done(blk_done), .xact_done(xact_done)
);

// File: tb/blkrep_seq_test.sv
module blkrep_seq_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_waddr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [3:0]  reg_raddr = '0;
  logic [7:0]  reg_rdata;
  logic        trigger = 1'b0;
  logic        beat_done = 1'b0;
  logic [23:0] src_addr;
  logic        chan_en, blk_done, xact_done;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // sampled at the end of a block
  bit end_blk, end_xact, end_en, early_blk;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkrep_seq uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .trigger(trigger), .beat_done(beat_done), .src_addr(src_addr),
    .chan_en(chan_en), .blk_done(blk_done), .xact_done(xact_done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = 4'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    reg_raddr = 4'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic set_addr(input logic [23:0] a);
    wr(4, a[7:0]); wr(5, a[15:8]); wr(6, a[23:16]);
  endtask

  // trigger, then n consecutive beats; extra trigger during beat index 1
  task automatic run_block(input int n, input bit extra_trig);
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
    early_blk = 0;
    for (int i = 0; i < n; i++) begin
      beat_done = 1'b1;
      trigger = extra_trig && (i == 1);
      @(negedge clk);
      if (i < n - 1 && blk_done) early_blk = 1;
    end
    beat_done = 1'b0; trigger = 1'b0;
    end_blk = blk_done; end_xact = xact_done; end_en = chan_en;
  endtask

  initial begin
    int v;
    #(CLK_PERIOD * 3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, v); check(v == 0, "R1 ctrl", v, 0);
    rd(1, v); check(v == 0, "R1 rep", v, 0);
    rd(2, v); check(v == 1, "R1 len lo", v, 1);
    rd(3, v); check(v == 1, "R1 len hi", v, 1);
    check(src_addr == 0, "R1 addr", src_addr, 0);
    check(!chan_en && !blk_done && !xact_done, "R1 outputs",
          {chan_en, blk_done, xact_done}, 0);

    // R5 atomic address load
    wr(4, 8'h34); check(src_addr == 0, "R5 staged lo", src_addr, 0);
    wr(5, 8'h12); check(src_addr == 0, "R5 staged mid", src_addr, 0);
    wr(6, 8'hAB); check(src_addr == 24'hAB1234, "R5 commit", src_addr, 24'hAB1234);
    rd(5, v); check(v == 8'h12, "R5 readback", v, 8'h12);

    // R9 trigger while disabled starts nothing
    wr(1, 0); wr(2, 2); wr(3, 0); wr(0, 32'h4);
    run_block(3, 0);
    check(!end_blk && src_addr == 24'hAB1234, "R9 disabled", src_addr, 24'hAB1234);

    // R2 R4 R6 sweep of length and direction, single block
    for (int len = 1; len <= 5; len++) begin
      for (int d = 0; d < 4; d++) begin
        logic [23:0] st, ex;
        st = 24'h000002;
        ex = (d == 1) ? st + 24'(len) : (d == 2) ? st - 24'(len) : st;
        set_addr(st);
        wr(2, len); wr(3, 0);
        wr(0, (d << 2) | 1);
        rd(0, v); check(v[0] == 1'b1, "R11 enable readback", v, (d << 2) | 1);
        run_block(len, 0);
        check(end_blk && !early_blk, "R2 block length", {early_blk, end_blk}, 1);
        check(end_xact && !end_en, "R6 single block off", {end_xact, end_en}, 2);
        check(src_addr == ex, "R4 address step", src_addr, ex);
        @(negedge clk);
        check(!blk_done && !xact_done, "R2 one cycle pulse", {blk_done, xact_done}, 0);
      end
    end

    // R10 programmed length unchanged
    rd(2, v); check(v == 5, "R10 len lo", v, 5);
    rd(3, v); check(v == 0, "R10 len hi", v, 0);

    // R9 trigger during block ignored; beats while idle ignored
    set_addr(24'h000100);
    wr(2, 4); wr(0, 32'h5);
    run_block(4, 1);
    check(end_blk && !early_blk, "R9 retrigger ignored", {early_blk, end_blk}, 1);
    check(src_addr == 24'h000104, "R9 addr after block", src_addr, 24'h000104);
    wr(0, 32'h5);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); beat_done = 1'b1;
    end
    @(negedge clk); beat_done = 1'b0;
    check(src_addr == 24'h000104 && !blk_done, "R9 idle beats", src_addr, 24'h000104);

    // R7 limited repeats
    set_addr(24'h000010);
    wr(2, 2); wr(1, 3); wr(0, 32'h7);
    for (int b = 1; b <= 3; b++) begin
      run_block(2, 0);
      rd(1, v);
      check(v == 3 - b, "R7 repeat count", v, 3 - b);
      check(end_en == (b < 3) && end_xact == (b == 3), "R7 stop point",
            {end_en, end_xact}, (b < 3) ? 2 : 1);
    end
    check(src_addr == 24'h000016, "R7 address", src_addr, 24'h000016);

    // R8 unlimited repeats
    wr(1, 0); wr(2, 3); wr(0, 32'h3);
    for (int b = 0; b < 4; b++) begin
      run_block(3, 0);
      rd(1, v);
      check(end_en && !end_xact && v == 0, "R8 unlimited", {end_en, end_xact, v[7:0]}, 10'h200);
    end

    // R11 disable stops a running block
    set_addr(24'h000200);
    wr(2, 8); wr(0, 32'h5);
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0; beat_done = 1'b1;
    @(negedge clk); beat_done = 1'b0;
    wr(0, 32'h4);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); beat_done = 1'b1;
    end
    @(negedge clk); beat_done = 1'b0;
    check(src_addr == 24'h000201 && !chan_en, "R11 stop", src_addr, 24'h000201);

    // R3 zero length gives 65535 beats
    set_addr(24'hFFFFF0);
    wr(2, 0); wr(3, 0); wr(0, 32'h5);
    run_block(65535, 0);
    check(end_blk && !early_blk, "R3 max block", {early_blk, end_blk}, 1);
    check(src_addr == 24'h00FFEF, "R3 address wrap", src_addr, 24'h00FFEF);

    done = 1;
  end

  initial begin
    for (int c = 0; c < 190000 && !done; c++) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule